// File: doc/BRIEF.md
# Dual-Mode Binary/BCD Adder-Subtractor

This block is purely combinational. It adds or subtracts two operands either as plain binary magnitudes or as packed decimal digit strings. A mode input selects the number system and an operation input selects addition or subtraction.

In binary mode each operand is a magnitude with a separate sign bit. The block works out whether the magnitudes must really be added or subtracted, and reports that decision on an output. It returns the magnitude and the sign of the result.

In decimal mode the operands are unsigned and their sign inputs are ignored. A sum wraps modulo ten to the number of digits. A difference is always the smaller value taken from the larger, and the result sign is always zero.

Both number systems share one parallel-prefix carry network. That network produces the carry-in-0 sum and the carry-in-1 sum in the same pass. Subtraction adds the complement of Y. The end-around carry then decides between two paths: taking the incremented sum, or inverting the plain sum to recover the magnitude. Decimal digits are pre-biased by six before the shared adder and un-biased afterwards when a digit produced no carry.

Top module: `dual_addsub`

## Requirements
- R1: With mode_bin=1 (binary), eff_add is 1 exactly when op_sub XOR x_sign XOR y_sign is 0. op_sub=0 requests addition and op_sub=1 requests subtraction.
- R2: In binary mode with eff_add=1, r_mag equals (x_mag + y_mag) modulo 2^(4*NDIG) and r_sign equals x_sign.
- R3: In binary mode with eff_add=0 and x_mag > y_mag, r_mag equals x_mag - y_mag and r_sign equals x_sign.
- R4: In binary mode with eff_add=0 and x_mag < y_mag, r_mag equals y_mag - x_mag and r_sign is the inverse of x_sign.
- R5: In binary mode with eff_add=0 and x_mag = y_mag, r_mag is 0 and r_sign is 0.
- R6: With mode_bin=0 (decimal) and op_sub=0, r_mag is the decimal sum of X and Y modulo 10^NDIG, and r_sign is 0. Decimal digit k occupies bits 4k+3..4k, and digit 0 is the least significant. 9999 plus 1 gives 0000.
- R7: In decimal mode with op_sub=1, r_mag is the decimal value |X - Y| and r_sign is 0. Equal operands give zero.
- R8: In decimal mode, x_sign and y_sign have no effect on any output, and eff_add is the inverse of op_sub.
- R9: In decimal mode, when every input digit is in the range 0..9, every result digit is also in the range 0..9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode_bin | input | 1 | 1 selects binary sign-magnitude arithmetic, 0 selects unsigned decimal |
| op_sub | input | 1 | 0 requests addition, 1 requests subtraction |
| x_sign | input | 1 | Sign of the first operand (binary mode only) |
| x_mag | input | 4*NDIG | First operand magnitude, or decimal digits |
| y_sign | input | 1 | Sign of the second operand (binary mode only) |
| y_mag | input | 4*NDIG | Second operand magnitude, or decimal digits |
| r_mag | output | 4*NDIG | Result magnitude, or decimal digits |
| r_sign | output | 1 | Result sign, always 0 in decimal mode |
| eff_add | output | 1 | 1 when the magnitudes were added, 0 when they were subtracted |

## Verification
The bench builds instance u0 with NDIG=2, which gives 8-bit operands.

That size lets the bench cover every decimal pair from 00 to 99 under both operations, and it toggles the ignored sign inputs at the same time. For binary it sweeps every value of x_mag against a strided set of y_mag values, under all eight combinations of sign and operation. This covers the carry and no-carry subtraction paths and the equal-magnitude zero.

A second instance with the default NDIG=4 takes the full-width corners, such as 9999 plus 1, 0 minus 9999 and 0xFFFF plus 1, followed by pseudo-random operands.

// File: rtl/das_pkg.sv
package das_pkg;

  localparam int DIG_W = 4;

  typedef enum logic {
    SYS_DEC = 1'b0,
    SYS_BIN = 1'b1
  } numsys_e;

  // Decide whether magnitudes are summed (1) or subtracted (0).
  function automatic logic eff_is_add(input logic bin, input logic op_sub,
                                      input logic xs, input logic ys);
    if (bin) return ~(op_sub ^ xs ^ ys);
    return ~op_sub;
  endfunction

  // Nine's complement of one decimal digit.
  function automatic logic [3:0] nines_comp(input logic [3:0] d);
    return 4'd9 - d;
  endfunction

  // Pre-correction bias applied to a decimal digit.
  function automatic logic [3:0] add_six(input logic [3:0] d);
    return d + 4'd6;
  endfunction

  // Removal of the bias for a digit that made no carry.
  function automatic logic [3:0] sub_six(input logic [3:0] d);
    return d - 4'd6;
  endfunction

  // Sign of the result; zero magnitudes from subtraction are never negative.
  function automatic logic result_sign(input logic bin, input logic eff_add,
                                       input logic end_cy, input logic zero,
                                       input logic xs);
    if (!bin)    return 1'b0;
    if (eff_add) return xs;
    if (zero)    return 1'b0;
    return end_cy ? xs : ~xs;
  endfunction

endpackage

// File: rtl/das_opnd_prep.sv
module das_opnd_prep
  import das_pkg::*;
#(
  parameter int NDIG = 4
) (
  input  logic                    mode_bin,
  input  logic                    eff_sub,
  input  logic [NDIG*DIG_W-1:0]   x_mag,
  input  logic [NDIG*DIG_W-1:0]   y_mag,
  output logic [NDIG*DIG_W-1:0]   a_op,
  output logic [NDIG*DIG_W-1:0]   b_op
);

  for (genvar k = 0; k < NDIG; k++) begin : g_dig
    logic [3:0] xd, yd, yd_dec, yd_bin;

    assign xd     = x_mag[k*DIG_W +: DIG_W];
    assign yd     = y_mag[k*DIG_W +: DIG_W];
    assign yd_bin = eff_sub ? ~yd : yd;
    assign yd_dec = eff_sub ? nines_comp(yd) : yd;

    assign a_op[k*DIG_W +: DIG_W] = mode_bin ? xd : add_six(xd);
    assign b_op[k*DIG_W +: DIG_W] = mode_bin ? yd_bin : yd_dec;
  end

endmodule

// File: rtl/das_prefix_core.sv
module das_prefix_core
  import das_pkg::*;
#(
  parameter int NDIG = 4
) (
  input  logic [NDIG*DIG_W-1:0] a,
  input  logic [NDIG*DIG_W-1:0] b,
  output logic [NDIG*DIG_W-1:0] sum_c0,
  output logic [NDIG*DIG_W-1:0] sum_c1,
  output logic [NDIG-1:0]       dcy_c0,
  output logic [NDIG-1:0]       dcy_c1
);

  localparam int W    = NDIG * DIG_W;
  localparam int LVLS = $clog2(W);

  wire [W-1:0] g_l [LVLS+1];
  wire [W-1:0] p_l [LVLS+1];
  logic [W-1:0] cy0, cy1;

  assign g_l[0] = a & b;
  assign p_l[0] = a ^ b;

  // Divide-and-conquer prefix: at level l the upper half of each 2^(l+1) block
  // combines with the last bit of the lower half.
  for (genvar l = 0; l < LVLS; l++) begin : g_lvl
    for (genvar i = 0; i < W; i++) begin : g_bit
      if (((i >> l) & 1) == 1) begin : g_merge
        localparam int J = ((i >> l) << l) - 1;
        assign g_l[l+1][i] = g_l[l][i] | (p_l[l][i] & g_l[l][J]);
        assign p_l[l+1][i] = p_l[l][i] & p_l[l][J];
      end else begin : g_pass
        assign g_l[l+1][i] = g_l[l][i];
        assign p_l[l+1][i] = p_l[l][i];
      end
    end
  end

  // Carry out of bit i for carry-in 0 and carry-in 1.
  assign cy0 = g_l[LVLS];
  assign cy1 = g_l[LVLS] | p_l[LVLS];

  assign sum_c0 = p_l[0] ^ {cy0[W-2:0], 1'b0};
  assign sum_c1 = p_l[0] ^ {cy1[W-2:0], 1'b1};

  for (genvar k = 0; k < NDIG; k++) begin : g_dcy
    assign dcy_c0[k] = cy0[k*DIG_W + DIG_W - 1];
    assign dcy_c1[k] = cy1[k*DIG_W + DIG_W - 1];
  end

endmodule

// File: rtl/das_result_fix.sv
module das_result_fix
  import das_pkg::*;
#(
  parameter int NDIG = 4
) (
  input  logic                  mode_bin,
  input  logic                  eff_sub,
  input  logic [NDIG*DIG_W-1:0] sum_c0,
  input  logic [NDIG*DIG_W-1:0] sum_c1,
  input  logic [NDIG-1:0]       dcy_c0,
  input  logic [NDIG-1:0]       dcy_c1,
  output logic [NDIG*DIG_W-1:0] mag
);

  localparam int W = NDIG * DIG_W;

  logic          use_inc;   // end-around carry present: take the +1 sum
  logic          invert;    // subtraction without carry: complement result
  logic [W-1:0]  sel_sum;
  logic [NDIG-1:0] sel_dcy;
  logic [W-1:0]  bin_mag;
  logic [W-1:0]  dec_mag;

  assign use_inc = eff_sub & dcy_c0[NDIG-1];
  assign invert  = eff_sub & ~dcy_c0[NDIG-1];
  assign sel_sum = use_inc ? sum_c1 : sum_c0;
  assign sel_dcy = use_inc ? dcy_c1 : dcy_c0;
  assign bin_mag = invert ? ~sel_sum : sel_sum;

  for (genvar k = 0; k < NDIG; k++) begin : g_dig
    logic [3:0] raw, unbiased;
    assign raw      = sel_sum[k*DIG_W +: DIG_W];
    assign unbiased = sel_dcy[k] ? raw : sub_six(raw);
    assign dec_mag[k*DIG_W +: DIG_W] = invert ? nines_comp(unbiased) : unbiased;
  end

  assign mag = mode_bin ? bin_mag : dec_mag;

endmodule

// File: rtl/dual_addsub.sv
module dual_addsub
  import das_pkg::*;
#(
  parameter int NDIG = 4
) (
  input  logic                  mode_bin,
  input  logic                  op_sub,
  input  logic                  x_sign,
  input  logic [NDIG*DIG_W-1:0] x_mag,
  input  logic                  y_sign,
  input  logic [NDIG*DIG_W-1:0] y_mag,
  output logic [NDIG*DIG_W-1:0] r_mag,
  output logic                  r_sign,
  output logic                  eff_add
);

  localparam int W = NDIG * DIG_W;

  logic            eff_sub;
  logic            end_carry;
  logic            mag_zero;
  logic [W-1:0]    a_op, b_op;
  logic [W-1:0]    sum_c0, sum_c1;
  logic [NDIG-1:0] dcy_c0, dcy_c1;

  assign eff_add = eff_is_add(mode_bin, op_sub, x_sign, y_sign);
  assign eff_sub = ~eff_add;

  das_opnd_prep #(.NDIG(NDIG)) u_prep (
    .mode_bin (mode_bin),
    .eff_sub  (eff_sub),
    .x_mag    (x_mag),
    .y_mag    (y_mag),
    .a_op     (a_op),
    .b_op     (b_op)
  );

  das_prefix_core #(.NDIG(NDIG)) u_core (
    .a      (a_op),
    .b      (b_op),
    .sum_c0 (sum_c0),
    .sum_c1 (sum_c1),
    .dcy_c0 (dcy_c0),
    .dcy_c1 (dcy_c1)
  );

  das_result_fix #(.NDIG(NDIG)) u_fix (
    .mode_bin (mode_bin),
    .eff_sub  (eff_sub),
    .sum_c0   (sum_c0),
    .sum_c1   (sum_c1),
    .dcy_c0   (dcy_c0),
    .dcy_c1   (dcy_c1),
    .mag      (r_mag)
  );

  assign end_carry = dcy_c0[NDIG-1];
  assign mag_zero  = ~|r_mag;
  assign r_sign    = result_sign(mode_bin, eff_add, end_carry, mag_zero, x_sign);

endmodule

// File: rtl/dual_addsub_chk.sv
module dual_addsub_chk
  import das_pkg::*;
#(
  parameter int NDIG = 4
) (
  input logic                  mode_bin,
  input logic                  op_sub,
  input logic                  x_sign,
  input logic [NDIG*DIG_W-1:0] x_mag,
  input logic                  y_sign,
  input logic [NDIG*DIG_W-1:0] y_mag,
  input logic [NDIG*DIG_W-1:0] r_mag,
  input logic                  r_sign,
  input logic                  eff_add,
  input logic                  end_carry
);

  localparam int W = NDIG * DIG_W;

  function automatic logic digits_ok(input logic [W-1:0] v);
    for (int k = 0; k < NDIG; k++)
      if (v[k*DIG_W +: DIG_W] > 4'd9) return 1'b0;
    return 1'b1;
  endfunction

  always_comb begin
    // R1
    p_same_sign_add_r1: assert (!(mode_bin && !op_sub && (x_sign == y_sign)) || eff_add)
      else $error("same-sign addition not effective add");
    p_bin_add_r2: assert (!(mode_bin && eff_add) ||
                          ((r_mag == W'(x_mag + y_mag)) && (r_sign == x_sign)))
      else $error("binary sum mismatch");
    p_end_carry_r3: assert (!(mode_bin && !eff_add && end_carry) ||
                            ((x_mag > y_mag) && (r_sign == x_sign)))
      else $error("end-around carry without larger X");
    p_small_x_r4: assert (!(mode_bin && !eff_add && (x_mag < y_mag)) ||
                          ((r_mag == W'(y_mag - x_mag)) && (r_sign != x_sign)))
      else $error("reverse subtraction mismatch");
    p_no_negzero_r5: assert (!(mode_bin && !eff_add && (r_mag == '0)) ||
                             (!r_sign && (x_mag == y_mag)))
      else $error("negative or false zero");
    p_dec_sign_r7: assert (mode_bin || !r_sign)
      else $error("decimal result signed");
    p_dec_eff_r8: assert (mode_bin || (eff_add != op_sub))
      else $error("decimal effective op depends on signs");
    p_dec_digits_r9: assert (mode_bin || !(digits_ok(x_mag) && digits_ok(y_mag)) ||
                             digits_ok(r_mag))
      else $error("decimal digit out of range");
  end

endmodule

bind dual_addsub dual_addsub_chk #(.NDIG(NDIG)) u_chk (
  .mode_bin  (mode_bin),
  .op_sub    (op_sub),
  .x_sign    (x_sign),
  .x_mag     (x_mag),
  .y_sign    (y_sign),
  .y_mag     (y_mag),
  .r_mag     (r_mag),
  .r_sign    (r_sign),
  .eff_add   (eff_add),
  .end_carry (end_carry)
);

// File: tb/sim_dual_addsub.sv
module sim_dual_addsub;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  int n_chk = 0;
  int n_bad = 0;

  // Small instance: 2 digits, 8 bits
  logic m0 = 1'b1, o0 = 1'b0, xs0 = 1'b0, ys0 = 1'b0;
  logic [7:0] x0 = '0, y0 = '0, r0;
  logic rs0, e0;

  dual_addsub #(.NDIG(2)) u0 (
    .mode_bin(m0), .op_sub(o0), .x_sign(xs0), .x_mag(x0),
    .y_sign(ys0), .y_mag(y0), .r_mag(r0), .r_sign(rs0), .eff_add(e0)
  );

  // Default instance: 4 digits, 16 bits
  logic m1 = 1'b1, o1 = 1'b0, xs1 = 1'b0, ys1 = 1'b0;
  logic [15:0] x1 = '0, y1 = '0, r1;
  logic rs1, e1;

  dual_addsub u1 (
    .mode_bin(m1), .op_sub(o1), .x_sign(xs1), .x_mag(x1),
    .y_sign(ys1), .y_mag(y1), .r_mag(r1), .r_sign(rs1), .eff_add(e1)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (eff,sign,mag)", tag, act, exp);
    end
  endtask

  function automatic int bcd2int(input logic [15:0] v, input int nd);
    int r = 0;
    for (int k = nd - 1; k >= 0; k--) r = r * 10 + int'(v[4*k +: 4]);
    return r;
  endfunction

  function automatic logic [15:0] int2bcd(input int v, input int nd);
    logic [15:0] r = '0;
    int t = v;
    for (int k = 0; k < nd; k++) begin
      r[4*k +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

  // Reference model written from the requirements.
  task automatic ref_calc(input logic bin, input logic op, input logic xs, input logic ys,
                          input logic [15:0] xv, input logic [15:0] yv, input int nd,
                          output logic [31:0] exp, output string tag);
    int mask = (1 << (4 * nd)) - 1;
    int modd = 10 ** nd;
    int x, y, mag;
    logic ef, sg;
    if (bin) begin
      x = int'(xv); y = int'(yv);
      ef = !(op ^ xs ^ ys);
      if (ef)         begin mag = (x + y) & mask; sg = xs;  tag = "R1 R2"; end
      else if (x > y) begin mag = x - y;          sg = xs;  tag = "R1 R3"; end
      else if (x < y) begin mag = y - x;          sg = !xs; tag = "R1 R4"; end
      else            begin mag = 0;              sg = 1'b0; tag = "R1 R5"; end
    end else begin
      x = bcd2int(xv, nd); y = bcd2int(yv, nd);
      ef = !op; sg = 1'b0;
      if (!op) begin mag = int'(int2bcd((x + y) % modd, nd)); tag = "R6 R8 R9"; end
      else begin
        mag = int'(int2bcd((x > y) ? x - y : y - x, nd));
        tag = "R7 R8 R9";
      end
    end
    exp = {14'b0, ef, sg, 16'(mag)};
  endtask

  task automatic run0(input logic bin, input logic op, input logic xs, input logic ys,
                      input logic [7:0] xv, input logic [7:0] yv);
    logic [31:0] exp;
    string tag;
    @(posedge clk);
    m0 = bin; o0 = op; xs0 = xs; ys0 = ys; x0 = xv; y0 = yv;
    @(negedge clk);
    ref_calc(bin, op, xs, ys, {8'b0, xv}, {8'b0, yv}, 2, exp, tag);
    chk(tag, {14'b0, e0, rs0, 8'b0, r0}, exp);
  endtask

  task automatic run1(input logic bin, input logic op, input logic xs, input logic ys,
                      input logic [15:0] xv, input logic [15:0] yv);
    logic [31:0] exp;
    string tag;
    @(posedge clk);
    m1 = bin; o1 = op; xs1 = xs; ys1 = ys; x1 = xv; y1 = yv;
    @(negedge clk);
    ref_calc(bin, op, xs, ys, xv, yv, 4, exp, tag);
    chk(tag, {14'b0, e1, rs1, r1}, exp);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // Idle state: zero operands, binary add -> zero, positive, effective add (R2)
    @(negedge clk);
    chk("R2 idle", {14'b0, e1, rs1, r1}, {14'b0, 1'b1, 1'b0, 16'h0000});

    // Binary sweep on the 8-bit instance: all x, strided y, every sign/op mix
    for (int x = 0; x < 256; x++)
      for (int y = 0; y < 256; y += 7)
        for (int c = 0; c < 8; c++)
          run0(1'b1, c[2], c[1], c[0], 8'(x), 8'(y));

    // Decimal exhaustive on two digits, sign inputs toggled (R8)
    for (int a = 0; a < 100; a++)
      for (int b = 0; b < 100; b++)
        for (int op = 0; op < 2; op++)
          run0(1'b0, op[0], a[0] ^ b[1], b[0], int2bcd(a, 2)[7:0], int2bcd(b, 2)[7:0]);

    // Full-width corners
    run1(1'b0, 1'b0, 1'b0, 1'b0, 16'h9999, 16'h0001);  // R6 wrap to 0000
    run1(1'b0, 1'b0, 1'b1, 1'b1, 16'h9999, 16'h9999);  // R6 R8
    run1(1'b0, 1'b1, 1'b0, 1'b0, 16'h9999, 16'h9999);  // R7 equal
    run1(1'b0, 1'b1, 1'b1, 1'b0, 16'h0000, 16'h0000);  // R7 zero
    run1(1'b0, 1'b1, 1'b0, 1'b0, 16'h0000, 16'h9999);  // R7 smaller first
    run1(1'b0, 1'b1, 1'b0, 1'b1, 16'h1234, 16'h5678);  // R7
    run1(1'b0, 1'b1, 1'b0, 1'b0, 16'h5000, 16'h0001);  // R7 borrow chain
    run1(1'b1, 1'b0, 1'b0, 1'b0, 16'hFFFF, 16'h0001);  // R2 wrap
    run1(1'b1, 1'b1, 1'b1, 1'b1, 16'hFFFF, 16'hFFFF);  // R5
    run1(1'b1, 1'b0, 1'b0, 1'b1, 16'h0000, 16'hFFFF);  // R4
    run1(1'b1, 1'b1, 1'b0, 1'b0, 16'h8000, 16'h7FFF);  // R3
    run1(1'b1, 1'b0, 1'b1, 1'b0, 16'h0000, 16'h0000);  // R5 zero

    // Pseudo-random full width
    begin
      logic [31:0] s = 32'h1D2C3B4A;
      for (int n = 0; n < 3000; n++) begin
        s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
        if (n[0])
          run1(1'b1, s[0], s[1], s[2], s[31:16], s[15:0]);
        else
          run1(1'b0, s[3], s[4], s[5], int2bcd(int'(s[31:16]) % 10000, 4),
               int2bcd(int'(s[15:0]) % 10000, 4));
      end
    end

    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL all requirements: actual timeout expected completion");
    summary();
    $finish;
  end

endmodule